// File: doc/BRIEF.md
# Cassette Tape Bit-Stream Encoder

This block turns an inclusive range of memory bytes into a single square-wave output line, in the form of a cassette audio recording. A one-cycle start pulse latches a 16-bit first address and a 16-bit last address. The block first emits a long leader tone of equal half-cycles. It then emits one short sync cycle, made of two unequal halves. After that it sends every byte of the range. Each bit is one full output cycle, and the length of its two equal halves carries the bit value.

Every change on the output is a toggle of one stored bit. Every half-cycle begins with such a toggle. All durations are counted in clock cycles and set by parameters, so the tone frequencies scale with the clock.

Bytes come from a synchronous read port: the block drives an address with a read strobe, and the data arrives one cycle later. Each read is issued during the half-cycle before the byte is needed, so the output runs without a gap from the leader to the last bit. When the final half-cycle has run out, a done flag pulses for one cycle. Nothing is appended after the last byte.

Top module: `tape_encoder`

## Requirements
- R1: After reset `tape_out`, `busy`, `done` and `mem_rd` are all 0.
- R2: A start pulse while idle toggles `tape_out` from 0 to 1 on the next clock edge and raises `busy`. This begins a leader of exactly LEAD_COUNT half-cycles, each LEAD_HALF clock cycles long.
- R3: Directly after the leader comes one sync cycle: a half of SYNC_FIRST cycles, then a half of SYNC_SECOND cycles.
- R4: Each data bit is two consecutive half-cycles of equal length: ZERO_HALF cycles for a 0 and ONE_HALF cycles for a 1. Bits go most significant first, 8 per byte.
- R5: Bytes are read from the start address upwards, including the end address. The address increments as a full 16-bit value, so a carry from the low byte reaches the high byte (0x00FF is followed by 0x0100).
- R6: The end test is "current address is greater than or equal to the end address", checked before the increment. When the start address exceeds the end address, exactly one byte is sent, the one at the start address.
- R7: Half-cycles follow one another without gaps. Every output toggle falls exactly one half-length after the previous toggle, including across byte boundaries.
- R8: `done` is high for exactly one cycle, one half-length after the last toggle, and `busy` falls at the same time. No further toggle follows (no checksum or trailer), and `tape_out` keeps its last level.
- R9: A start pulse while `busy` is high has no effect on the output stream, the addresses read or the finish time.
- R10: `mem_rd` pulses once per byte with `mem_addr` holding that byte's address. `mem_data` is taken one cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| start_addr | input | ADDR_W | First address of the range, latched at start |
| end_addr | input | ADDR_W | Last address of the range, latched at start |
| mem_addr | output | ADDR_W | Read address, valid while mem_rd is high |
| mem_rd | output | 1 | Read strobe; data expected one cycle later |
| mem_data | input | DATA_W | Read data returned by memory |
| tape_out | output | 1 | Square-wave tape output |
| busy | output | 1 | High from the accepted start until completion |
| done | output | 1 | One-cycle pulse when the transfer ends |

## Verification
The scoreboard measures every interval between toggles. A leader that is one half too long or too short, or a swapped sync pair, therefore shows up as a misaligned length rather than being hidden in a total. The range that straddles 0x00FF/0x0100 catches an increment that does not carry into the high byte: such a design would read 0x0000 and repeat data. The reversed range catches an end test written as an equality, which would keep reading until the address wrapped. A start pulse injected mid-transfer catches a design that restarts. A fetch issued too late for the last half of a byte would show as a stretched half at the byte boundary or as a wrong bit pattern.

// File: rtl/tape_enc_pkg.sv
package tape_enc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SYNC1,
        ST_SYNC2,
        ST_DATA
    } tenc_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/tape_half_timer.sv
module tape_half_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CNT_W'(1));

    // R7: a half-cycle of length zero would break the toggle spacing
    a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

    // R7: the timer never sits at zero right after a load
    a_r7_runs_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));
endmodule

// File: rtl/tape_addr_walk.sv
module tape_addr_walk #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              fetch,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              at_end
);
    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] lim;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (init) begin
            w_d.cur = first_addr;
            w_d.lim = last_addr;
        end else if (fetch) begin
            w_d.cur = w_q.cur + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign rd_addr = w_q.cur;
    assign at_end  = (w_q.cur >= w_q.lim);

    // R5: after each read the next address is one above the one read
    a_r5_step_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !init) |=> (rd_addr == $past(rd_addr) + 1'b1));
endmodule

// File: rtl/tape_encoder.sv
module tape_encoder
    import tape_enc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int LEAD_HALF   = 650,
    parameter int LEAD_COUNT  = 15300,
    parameter int SYNC_FIRST  = 180,
    parameter int SYNC_SECOND = 200,
    parameter int ZERO_HALF   = 250,
    parameter int ONE_HALF    = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_data,
    output logic              tape_out,
    output logic              busy,
    output logic              done
);
    localparam int MAXH  = imax(imax(imax(LEAD_HALF, SYNC_FIRST),
                                     imax(SYNC_SECOND, ZERO_HALF)), ONE_HALF);
    localparam int CNT_W = $clog2(MAXH + 1);
    localparam int LC_W  = $clog2(LEAD_COUNT + 1);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        tenc_state_e       st;
        logic              out;
        logic [LC_W-1:0]   lead_left;
        logic [BIT_W-1:0]  bit_idx;
        logic              second;
        logic [DATA_W-1:0] shreg;
        logic              cur_last;
        logic [DATA_W-1:0] nxt_data;
        logic              nxt_last;
        logic              rd;
        logic              done;
    } enc_t;

    enc_t q, n;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_exp;
    logic             walk_init;
    logic             walk_fetch;
    logic             fetch_last;

    function automatic logic [CNT_W-1:0] bit_len(input logic b);
        return b ? CNT_W'(ONE_HALF) : CNT_W'(ZERO_HALF);
    endfunction

    tape_half_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .expire (tmr_exp)
    );

    tape_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (walk_init),
        .first_addr (start_addr),
        .last_addr  (end_addr),
        .fetch      (walk_fetch),
        .rd_addr    (mem_addr),
        .at_end     (fetch_last)
    );

    always_comb begin
        n          = q;
        n.done     = 1'b0;
        tmr_load   = 1'b0;
        tmr_len    = '0;
        walk_init  = 1'b0;
        walk_fetch = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.st        = ST_LEAD;
                    n.out       = ~q.out;
                    n.lead_left = LC_W'(LEAD_COUNT - 1);
                    tmr_load    = 1'b1;
                    tmr_len     = CNT_W'(LEAD_HALF);
                    walk_init   = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_exp) begin
                    n.out    = ~q.out;
                    tmr_load = 1'b1;
                    if (q.lead_left == '0) begin
                        n.st       = ST_SYNC1;
                        tmr_len    = CNT_W'(SYNC_FIRST);
                        walk_fetch = 1'b1;
                    end else begin
                        n.lead_left = q.lead_left - 1'b1;
                        tmr_len     = CNT_W'(LEAD_HALF);
                    end
                end
            end
            ST_SYNC1: begin
                if (tmr_exp) begin
                    n.st     = ST_SYNC2;
                    n.out    = ~q.out;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(SYNC_SECOND);
                end
            end
            ST_SYNC2: begin
                if (tmr_exp) begin
                    n.st       = ST_DATA;
                    n.out      = ~q.out;
                    n.shreg    = q.nxt_data;
                    n.cur_last = q.nxt_last;
                    n.bit_idx  = BIT_W'(DATA_W - 1);
                    n.second   = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_len    = bit_len(q.nxt_data[DATA_W-1]);
                end
            end
            ST_DATA: begin
                if (tmr_exp) begin
                    if (!q.second) begin
                        n.out      = ~q.out;
                        n.second   = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_len    = bit_len(q.shreg[DATA_W-1]);
                        walk_fetch = (q.bit_idx == '0) && !q.cur_last;
                    end else if (q.bit_idx != '0) begin
                        n.out     = ~q.out;
                        n.second  = 1'b0;
                        n.shreg   = q.shreg << 1;
                        n.bit_idx = q.bit_idx - 1'b1;
                        tmr_load  = 1'b1;
                        tmr_len   = bit_len(q.shreg[DATA_W-2]);
                    end else if (!q.cur_last) begin
                        n.out      = ~q.out;
                        n.second   = 1'b0;
                        n.shreg    = q.nxt_data;
                        n.cur_last = q.nxt_last;
                        n.bit_idx  = BIT_W'(DATA_W - 1);
                        tmr_load   = 1'b1;
                        tmr_len    = bit_len(q.nxt_data[DATA_W-1]);
                    end else begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase

        if (q.rd)
            n.nxt_data = mem_data;
        if (walk_fetch)
            n.nxt_last = fetch_last;
        n.rd = walk_fetch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign tape_out = q.out;
    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign mem_rd   = walk_fetch;

    // R8: done lasts one cycle only
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy has dropped when done is seen
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: an idle block without a start keeps its output level
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(tape_out));

    // R9: a start while busy changes neither output nor address
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !tmr_exp) |=> ($stable(tape_out) && $stable(mem_addr)));

    // R10: reads happen only during a transfer, never back to back
    a_r10_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);
    a_r10_read_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
endmodule

// File: tb/sim_tape_encoder.sv
`timescale 1ns/1ps
module sim_tape_encoder;
    localparam int LH = 3, LC = 6, SA = 4, SB = 5, ZH = 2, OH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0, end_addr = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_data = '0;
    logic        tape_out, busy, done;

    tape_encoder #(
        .ADDR_W(16), .DATA_W(8), .LEAD_HALF(LH), .LEAD_COUNT(LC),
        .SYNC_FIRST(SA), .SYNC_SECOND(SB), .ZERO_HALF(ZH), .ONE_HALF(OH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .end_addr(end_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_data(mem_data), .tape_out(tape_out), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat(input logic [15:0] a);
        logic [7:0] m;
        m = 8'(a[7:0] * 8'd37);
        return m ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) if (mem_rd) mem_data <= pat(mem_addr);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard queues
    int    len_q[$];
    string tag_q[$];
    int    adr_q[$];
    logic  prev_out = 1'b0;
    bit    have_prev = 0;
    int    last_stamp = 0;
    int    done_seen = 0;

    task automatic pop_len(input int act);
        if (len_q.size() == 0) begin
            check("R8 extra half-cycle", act, -1);
        end else begin
            int e;
            string t;
            e = len_q.pop_front();
            t = tag_q.pop_front();
            check(t, act, e);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (tape_out !== prev_out) begin
                if (have_prev) pop_len(cyc - last_stamp);
                have_prev  = 1;
                last_stamp = cyc;
            end
            if (done) begin
                pop_len(cyc - last_stamp);
                have_prev = 0;
                done_seen++;
            end
            if (mem_rd) begin
                if (adr_q.size() == 0) check("R10 unexpected read", int'(mem_addr), -1);
                else check("R5 R10 read address", int'(mem_addr), adr_q.pop_front());
            end
        end
        prev_out = tape_out;
    end

    task automatic push_half(input int len, input string tag);
        len_q.push_back(len);
        tag_q.push_back(tag);
    endtask

    task automatic run(input logic [15:0] s, input logic [15:0] e, input bit poke);
        logic [15:0] a;
        logic [7:0]  b;
        bit          last;
        int          d0, t;
        for (int i = 0; i < LC; i++) push_half(LH, "R2 leader half");
        push_half(SA, "R3 sync first half");
        push_half(SB, "R3 sync second half");
        a = s;
        do begin
            adr_q.push_back(int'(a));
            b = pat(a);
            for (int k = 7; k >= 0; k--) begin
                push_half(b[k] ? OH : ZH, "R4 R7 data half 1");
                push_half(b[k] ? OH : ZH, "R4 R7 data half 2");
            end
            last = (a >= e);
            a = a + 16'd1;
        end while (!last);

        d0 = done_seen;
        @(negedge clk);
        start_addr = s;
        end_addr   = e;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        check("R2 first level", int'(tape_out), 1);
        check("R2 busy raised", int'(busy), 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            start_addr = 16'h0000;
            end_addr   = 16'hFFFF;
            start      = 1'b1;
            @(negedge clk);
            start      = 1'b0;
            repeat (30) @(negedge clk);
            start      = 1'b1;
            @(negedge clk);
            start      = 1'b0;
        end
        t = 0;
        while (done_seen == d0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check("R8 done reached", int'(done_seen > d0), 1);
        check("R8 busy low at done", int'(busy), 0);
        @(negedge clk);
        check("R8 done single cycle", int'(done), 0);
        repeat (12) @(negedge clk);
        check("R8 final level held", int'(tape_out), 0);
        check("R8 R9 all halves consumed", len_q.size(), 0);
        check("R6 R10 all reads made", adr_q.size(), 0);
        len_q.delete();
        tag_q.delete();
        adr_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 tape_out reset", int'(tape_out), 0);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        check("R1 mem_rd reset", int'(mem_rd), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", int'(busy), 0);

        run(16'h0010, 16'h0012, 1'b0);   // R4 R5 three-byte range
        run(16'h00FE, 16'h0101, 1'b0);   // R5 carry into high byte
        run(16'h0200, 16'h01FF, 1'b0);   // R6 reversed range: one byte
        run(16'h0040, 16'h0041, 1'b1);   // R9 start pulses while busy
        run(16'hFFFF, 16'hFFFF, 1'b0);   // R6 single byte at top address
        run(16'h1234, 16'h1234, 1'b0);   // R7 single byte, other pattern

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule